// File: doc/BRIEF.md
# One-Way Security Lock Register Bank

This block holds the protection state that a boot sequence uses to close off sensitive memory before handing control to less trusted code. It carries set-only lock bits that hide the primary and secondary boot ROM windows and the one-time-programmable data window. It also carries a clear-only bit that holds a secondary processor in reset until software releases it. Under the register bank's direct control are a show/hide bit for an extended memory region and a boot-environment value that records which operating mode ran last.

Software reaches the registers over a simple byte-addressed write-strobe bus with combinational read data. The windows that the lock bits guard are modelled as a small internal RAM with four regions. A hidden region reads as zero and drops writes, and its stored contents are preserved. A hard reset returns every lock to its open state and clears the boot-environment value. A soft reset only hides the extended region and leaves all locks and the boot-environment value as they were.

Top module: `lockbank`

## Requirements
- R1: After a hard reset the registers read: address 0x0 = 0x00, 0x1 = 0x00, 0x2 = 0x01, 0x4 = 0x00, 0x8 = 0x00. The outputs read bootRomAOff=0, mainRamOn=0, otpOff=0, bootRomBOff=0, secCpuHold=1 and extShown=0.
- R2: Bit 0 of register 0x0 is set-only. Writing 1 asserts bootRomAOff and mainRamOn, and a later write of 0 does not clear it.
- R3: Bit 1 of register 0x0 is set-only. Writing 1 asserts otpOff, and a later write of 0 does not clear it.
- R4: Bits of 0x0 above bit 1 and bits of 0x1 above bit 0 cannot be set and always read as 0.
- R5: Bit 0 of register 0x1 is set-only. Writing 1 asserts bootRomBOff.
- R6: Bit 0 of register 0x2 starts at 1. Writing 0 clears it and drops secCpuHold. After that, a write of 1 never sets it again.
- R7: Bit 0 of register 0x4 shows the extended region (memRegion 3) when 1 and hides it when 0. It can be written both ways. Data held in the region is unchanged across a hide and re-show, and a soft reset clears this bit.
- R8: Register 0x8 is a full-width read/write boot-environment value. It survives a soft reset and is cleared by a hard reset.
- R9: A soft reset leaves registers 0x0, 0x1 and 0x2 unchanged.
- R10: Each gate output changes on the clock edge that captures the write changing it, and not earlier.
- R11: While a region is hidden, memRdata reads 0 and writes to it are dropped. Regions are memRegion 0 (primary boot ROM, hidden by 0x0 bit 0), 1 (OTP data, hidden by 0x0 bit 1), 2 (secondary boot ROM, hidden by 0x1 bit 0) and 3 (extended, hidden while 0x4 bit 0 is 0).
- R12: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous active-low hard reset, clears all state |
| softRstN | input | 1 | Synchronous active-low soft reset, hides extended region only |
| busValid | input | 1 | Bus access strobe, one cycle per write |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | AW (4) | Byte address |
| busWdata | input | DW (8) | Write data |
| busRdata | output | DW (8) | Combinational read data, 0 when idle or unmapped |
| memWrite | input | 1 | Window RAM write strobe |
| memRegion | input | 2 | Window region select |
| memIndex | input | clog2(WIN_WORDS) (2) | Word index inside the region |
| memWdata | input | DW (8) | Window write data |
| memRdata | output | DW (8) | Window read data, 0 when region hidden |
| bootRomAOff | output | 1 | Primary boot ROM window closed |
| mainRamOn | output | 1 | Main RAM window opened |
| otpOff | output | 1 | OTP data window closed |
| bootRomBOff | output | 1 | Secondary boot ROM window closed |
| secCpuHold | output | 1 | Secondary processor held in reset |
| extShown | output | 1 | Extended region visible |

## Verification
A lock write and a window read can fall in the same cycle: the bench sets the OTP lock on the bus while memRdata is reading a preloaded OTP word. The read in that cycle must still return the stored word because the gate is registered. From the next cycle on, with the address held, the same read must return zero. The same timing is judged on the primary boot ROM lock, where the gate output is sampled just before and just after the capturing edge.

// File: rtl/lockbank_pkg.sv
package lockbank_pkg;
  localparam int ADDR_PROT_A = 0;
  localparam int ADDR_PROT_B = 1;
  localparam int ADDR_HOLD   = 2;
  localparam int ADDR_EXT    = 4;
  localparam int ADDR_ENV    = 8;

  localparam int NUM_WIN    = 4;
  localparam int RW         = $clog2(NUM_WIN);
  localparam int WIN_BOOT_A = 0;
  localparam int WIN_OTP    = 1;
  localparam int WIN_BOOT_B = 2;
  localparam int WIN_EXT    = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PROT_A,
    SEL_PROT_B,
    SEL_HOLD,
    SEL_EXT,
    SEL_ENV
  } rdSel_e;

  typedef struct packed {
    logic setProtA;
    logic setProtB;
    logic wrHold;
    logic wrExt;
    logic wrEnv;
  } wrStrobe_t;
endpackage

// File: rtl/lockbank_ctrl.sv
module lockbank_ctrl
  import lockbank_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  output wrStrobe_t     strb,
  output rdSel_e        rdSel
);
  rdSel_e addrSel;

  always_comb begin
    case (busAddr)
      AW'(ADDR_PROT_A): addrSel = SEL_PROT_A;
      AW'(ADDR_PROT_B): addrSel = SEL_PROT_B;
      AW'(ADDR_HOLD):   addrSel = SEL_HOLD;
      AW'(ADDR_EXT):    addrSel = SEL_EXT;
      AW'(ADDR_ENV):    addrSel = SEL_ENV;
      default:          addrSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb  = '0;
    rdSel = SEL_NONE;
    if (busValid && busWrite) begin
      strb.setProtA = (addrSel == SEL_PROT_A);
      strb.setProtB = (addrSel == SEL_PROT_B);
      strb.wrHold   = (addrSel == SEL_HOLD);
      strb.wrExt    = (addrSel == SEL_EXT);
      strb.wrEnv    = (addrSel == SEL_ENV);
    end else if (busValid) begin
      rdSel = addrSel;
    end
  end
endmodule

// File: rtl/lockbank_dp.sv
module lockbank_dp
  import lockbank_pkg::*;
#(
  parameter int DW        = 8,
  parameter int WIN_WORDS = 4,
  localparam int IW       = $clog2(WIN_WORDS)
) (
  input  logic          clk,
  input  logic          hardRstN,
  input  logic          softRstN,
  input  wrStrobe_t     strb,
  input  rdSel_e        rdSel,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  input  logic          memWrite,
  input  logic [RW-1:0] memRegion,
  input  logic [IW-1:0] memIndex,
  input  logic [DW-1:0] memWdata,
  output logic [DW-1:0] memRdata,
  output logic          bootRomAOff,
  output logic          mainRamOn,
  output logic          otpOff,
  output logic          bootRomBOff,
  output logic          secCpuHold,
  output logic          extShown
);
  logic [1:0]    protA;
  logic          protB;
  logic          holdBit;
  logic          extEn;
  logic [DW-1:0] bootEnv;

  // one-way lock state, cleared only by the hard reset
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      protA   <= '0;
      protB   <= 1'b0;
      holdBit <= 1'b1;
      bootEnv <= '0;
    end else begin
      if (strb.setProtA) protA   <= protA | busWdata[1:0];
      if (strb.setProtB) protB   <= protB | busWdata[0];
      if (strb.wrHold)   holdBit <= holdBit & busWdata[0];
      if (strb.wrEnv)    bootEnv <= busWdata;
    end
  end

  // extended region visibility: two-way, soft reset hides it
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)       extEn <= 1'b0;
    else if (!softRstN)  extEn <= 1'b0;
    else if (strb.wrExt) extEn <= busWdata[0];
  end

  always_comb begin
    case (rdSel)
      SEL_PROT_A: busRdata = DW'(protA);
      SEL_PROT_B: busRdata = DW'(protB);
      SEL_HOLD:   busRdata = DW'(holdBit);
      SEL_EXT:    busRdata = DW'(extEn);
      SEL_ENV:    busRdata = bootEnv;
      default:    busRdata = '0;
    endcase
  end

  logic [NUM_WIN-1:0] winVisible;
  logic [DW-1:0]      winRd [NUM_WIN];

  assign winVisible[WIN_BOOT_A] = ~protA[0];
  assign winVisible[WIN_OTP]    = ~protA[1];
  assign winVisible[WIN_BOOT_B] = ~protB;
  assign winVisible[WIN_EXT]    = extEn;

  for (genvar r = 0; r < NUM_WIN; r++) begin : g_win
    logic [DW-1:0] store [WIN_WORDS];
    always_ff @(posedge clk) begin
      if (memWrite && (memRegion == RW'(r)) && winVisible[r])
        store[memIndex] <= memWdata;
    end
    assign winRd[r] = store[memIndex];
  end

  assign memRdata = winVisible[memRegion] ? winRd[memRegion] : '0;

  assign bootRomAOff = protA[0];
  assign mainRamOn   = protA[0];
  assign otpOff      = protA[1];
  assign bootRomBOff = protB;
  assign secCpuHold  = holdBit;
  assign extShown    = extEn;
endmodule

// File: rtl/lockbank.sv
module lockbank
  import lockbank_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int WIN_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         hardRstN,
  input  logic                         softRstN,
  input  logic                         busValid,
  input  logic                         busWrite,
  input  logic [AW-1:0]                busAddr,
  input  logic [DW-1:0]                busWdata,
  output logic [DW-1:0]                busRdata,
  input  logic                         memWrite,
  input  logic [RW-1:0]                memRegion,
  input  logic [$clog2(WIN_WORDS)-1:0] memIndex,
  input  logic [DW-1:0]                memWdata,
  output logic [DW-1:0]                memRdata,
  output logic                         bootRomAOff,
  output logic                         mainRamOn,
  output logic                         otpOff,
  output logic                         bootRomBOff,
  output logic                         secCpuHold,
  output logic                         extShown
);
  wrStrobe_t strb;
  rdSel_e    rdSel;

  lockbank_ctrl #(.AW(AW)) i_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb),
    .rdSel    (rdSel)
  );

  lockbank_dp #(.DW(DW), .WIN_WORDS(WIN_WORDS)) i_dp (
    .clk         (clk),
    .hardRstN    (hardRstN),
    .softRstN    (softRstN),
    .strb        (strb),
    .rdSel       (rdSel),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .memWrite    (memWrite),
    .memRegion   (memRegion),
    .memIndex    (memIndex),
    .memWdata    (memWdata),
    .memRdata    (memRdata),
    .bootRomAOff (bootRomAOff),
    .mainRamOn   (mainRamOn),
    .otpOff      (otpOff),
    .bootRomBOff (bootRomBOff),
    .secCpuHold  (secCpuHold),
    .extShown    (extShown)
  );
endmodule

// File: rtl/lockbank_chk.sv
module lockbank_chk
  import lockbank_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          hardRstN,
  input logic          softRstN,
  input logic          busValid,
  input logic          busWrite,
  input logic [AW-1:0] busAddr,
  input logic [DW-1:0] busWdata,
  input logic [RW-1:0] memRegion,
  input logic [DW-1:0] memRdata,
  input logic          bootRomAOff,
  input logic          mainRamOn,
  input logic          otpOff,
  input logic          bootRomBOff,
  input logic          secCpuHold,
  input logic          extShown
);
  AST_ROM_A_STICKY: assert property (@(posedge clk) disable iff (!hardRstN)
    bootRomAOff |=> bootRomAOff); // R2

  AST_MAIN_RAM_FOLLOWS: assert property (@(posedge clk) disable iff (!hardRstN)
    mainRamOn == bootRomAOff); // R2

  AST_OTP_STICKY: assert property (@(posedge clk) disable iff (!hardRstN)
    otpOff |=> otpOff); // R3

  AST_ROM_B_STICKY: assert property (@(posedge clk) disable iff (!hardRstN)
    bootRomBOff |=> bootRomBOff); // R5

  AST_HOLD_ONE_WAY: assert property (@(posedge clk) disable iff (!hardRstN)
    !secCpuHold |=> !secCpuHold); // R6

  AST_SOFT_HIDES_EXT: assert property (@(posedge clk) disable iff (!hardRstN)
    !softRstN |=> !extShown); // R7

  AST_GATE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!hardRstN)
    (busValid && busWrite && busAddr == AW'(ADDR_PROT_A) && busWdata[0] && !bootRomAOff)
      |=> bootRomAOff); // R10

  AST_OTP_READS_ZERO: assert property (@(posedge clk) disable iff (!hardRstN)
    (memRegion == RW'(WIN_OTP) && otpOff) |-> memRdata == '0); // R11
endmodule

bind lockbank lockbank_chk #(.DW(DW), .AW(AW)) i_chk (
  .clk         (clk),
  .hardRstN    (hardRstN),
  .softRstN    (softRstN),
  .busValid    (busValid),
  .busWrite    (busWrite),
  .busAddr     (busAddr),
  .busWdata    (busWdata),
  .memRegion   (memRegion),
  .memRdata    (memRdata),
  .bootRomAOff (bootRomAOff),
  .mainRamOn   (mainRamOn),
  .otpOff      (otpOff),
  .bootRomBOff (bootRomBOff),
  .secCpuHold  (secCpuHold),
  .extShown    (extShown)
);

// File: tb/test_lockbank.sv
module test_lockbank;
  logic       clk = 1'b0;
  logic       hardRstN = 1'b0;
  logic       softRstN = 1'b1;
  logic       busValid = 1'b0;
  logic       busWrite = 1'b0;
  logic [3:0] busAddr  = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       memWrite = 1'b0;
  logic [1:0] memRegion = '0;
  logic [1:0] memIndex  = '0;
  logic [7:0] memWdata  = '0;
  logic [7:0] memRdata;
  logic bootRomAOff, mainRamOn, otpOff, bootRomBOff, secCpuHold, extShown;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lockbank i_lockbank (
    .clk(clk), .hardRstN(hardRstN), .softRstN(softRstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .memWrite(memWrite), .memRegion(memRegion), .memIndex(memIndex),
    .memWdata(memWdata), .memRdata(memRdata),
    .bootRomAOff(bootRomAOff), .mainRamOn(mainRamOn), .otpOff(otpOff),
    .bootRomBOff(bootRomBOff), .secCpuHold(secCpuHold), .extShown(extShown)
  );

  function automatic logic [7:0] pat(input int r, input int i);
    return 8'(8'h40 + r * 16 + i);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [7:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic memWr(input int r, input int i, input logic [7:0] d);
    @(negedge clk);
    memWrite = 1'b1; memRegion = 2'(r); memIndex = 2'(i); memWdata = d;
    @(negedge clk);
    memWrite = 1'b0;
  endtask

  task automatic memRd(input int r, input int i, output logic [7:0] d);
    memRegion = 2'(r); memIndex = 2'(i);
    #1 d = memRdata;
  endtask

  task automatic checkReg(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    busRd(a, v);
    check(req, v, exp);
  endtask

  task automatic checkMem(input string req, input int r, input int i, input logic [7:0] exp);
    logic [7:0] v;
    memRd(r, i, v);
    check(req, v, exp);
  endtask

  task automatic checkResetState(input string tag);
    checkReg({tag, " R1 reg0"}, 4'h0, 8'h00);
    checkReg({tag, " R1 reg1"}, 4'h1, 8'h00);
    checkReg({tag, " R1 reg2"}, 4'h2, 8'h01);
    checkReg({tag, " R1 reg4"}, 4'h4, 8'h00);
    checkReg({tag, " R1 reg8"}, 4'h8, 8'h00);
    check({tag, " R1 outputs"},
          {2'b0, bootRomAOff, mainRamOn, otpOff, bootRomBOff, secCpuHold, extShown},
          8'b0000_0010);
  endtask

  task automatic testPreload();
    busWr(4'h4, 8'h01);
    check("R7 ext shown after enable", 8'(extShown), 8'h01);
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 4; i++)
        memWr(r, i, pat(r, i));
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 4; i++)
        checkMem("R11 visible readback", r, i, pat(r, i));
  endtask

  task automatic testPrimaryLock();
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 4'h0; busWdata = 8'h01;
    #1 check("R10 rom A gate before edge", 8'(bootRomAOff), 8'h00);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    check("R10 rom A gate after edge", 8'(bootRomAOff), 8'h01);
    check("R2 main RAM opened", 8'(mainRamOn), 8'h01);
    checkMem("R11 rom A reads zero", 0, 2, 8'h00);
    busWr(4'h0, 8'h00);
    checkReg("R2 bit0 not clearable", 4'h0, 8'h01);
    busWr(4'h0, 8'hFC);
    checkReg("R4 reg0 upper bits", 4'h0, 8'h01);
    busWr(4'h1, 8'hFE);
    checkReg("R4 reg1 upper bits", 4'h1, 8'h00);
  endtask

  task automatic testOtpCollision();
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 4'h0; busWdata = 8'h02;
    memRegion = 2'd1; memIndex = 2'd1;
    #1;
    check("R10 OTP read same cycle as lock", memRdata, pat(1, 1));
    check("R10 otpOff before edge", 8'(otpOff), 8'h00);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    #1;
    check("R3 OTP read after lock", memRdata, 8'h00);
    check("R3 otpOff set", 8'(otpOff), 8'h01);
    busWr(4'h0, 8'h00);
    checkReg("R3 bit1 not clearable", 4'h0, 8'h03);
    memWr(1, 0, 8'hAA);
    checkMem("R11 hidden OTP write reads zero", 1, 0, 8'h00);
  endtask

  task automatic testExtHide();
    busWr(4'h4, 8'h00);
    check("R7 ext hidden", 8'(extShown), 8'h00);
    checkMem("R7 hidden ext reads zero", 3, 2, 8'h00);
    memWr(3, 2, 8'h55);
    busWr(4'h4, 8'h01);
    checkMem("R11 hidden write dropped", 3, 2, pat(3, 2));
    checkMem("R7 data kept across hide", 3, 0, pat(3, 0));
  endtask

  task automatic testSecondary();
    busWr(4'h1, 8'h01);
    check("R5 rom B gate", 8'(bootRomBOff), 8'h01);
    checkMem("R5 rom B reads zero", 2, 1, 8'h00);
    busWr(4'h1, 8'h00);
    checkReg("R5 bit not clearable", 4'h1, 8'h01);
    busWr(4'h2, 8'h00);
    check("R6 hold released", 8'(secCpuHold), 8'h00);
    busWr(4'h2, 8'h01);
    check("R6 hold cannot return", 8'(secCpuHold), 8'h00);
    checkReg("R6 reg2 reads 0", 4'h2, 8'h00);
  endtask

  task automatic testEnvAndUnmapped();
    busWr(4'h8, 8'h03);
    checkReg("R8 env 3", 4'h8, 8'h03);
    busWr(4'h8, 8'h07);
    checkReg("R8 env 7", 4'h8, 8'h07);
    checkReg("R12 addr 3", 4'h3, 8'h00);
    checkReg("R12 addr F", 4'hF, 8'h00);
    busWr(4'h5, 8'hFF);
    checkReg("R12 write to unmapped", 4'h5, 8'h00);
  endtask

  task automatic testSoftReset();
    @(negedge clk);
    softRstN = 1'b0;
    @(negedge clk);
    softRstN = 1'b1;
    checkReg("R9 reg0 after soft", 4'h0, 8'h03);
    checkReg("R9 reg1 after soft", 4'h1, 8'h01);
    checkReg("R9 reg2 after soft", 4'h2, 8'h00);
    checkReg("R8 env after soft", 4'h8, 8'h07);
    check("R7 soft reset hides ext", 8'(extShown), 8'h00);
    busWr(4'h4, 8'h01);
    checkMem("R7 ext data after soft", 3, 1, pat(3, 1));
  endtask

  task automatic testHardReset();
    @(negedge clk);
    hardRstN = 1'b0;
    @(negedge clk);
    hardRstN = 1'b1;
    checkResetState("hard");
    checkMem("R1 OTP visible again", 1, 3, pat(1, 3));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    hardRstN = 1'b1;
    @(negedge clk);
    checkResetState("cold");
    testPreload();
    testPrimaryLock();
    testOtpCollision();
    testExtHide();
    testSecondary();
    testEnvAndUnmapped();
    testSoftReset();
    testHardReset();
    repeat (2) @(negedge clk);
    finish();
  end
endmodule